// File: doc/BRIEF.md
# Context Tag CRC-8 Validator

This block forms and checks the one-byte integrity tag that guards a stored connection context. For each request it packs a 24-bit connection identifier, a 4-bit region number and a 4-bit type code into a 32-bit check word. It then runs an 8-bit CRC over the whole word in a single cycle. The polynomial is x^8 + x^2 + x + 1 and the register starts at all ones.

Three operations share one request port. A make operation returns a fresh tag with its valid flag set. A check operation compares a tag read back from context storage against the CRC for the same identifier, region and type, and reports one of three results: the tag is marked invalid, it matches, or it does not match. A kill operation returns the presented tag with its valid flag cleared, which retires the context. The block also flags the two aggregation regions, whose contexts must always carry a tag.

Every result is registered, so a response appears one clock after its request. The block keeps no context storage of its own.

Top module: `ctag_validator`

## Requirements
- R1: The check word is built with the connection ID in bits 31:8, the region in bits 7:4 and the type in bits 3:0.
- R2: `rsp_crc` is the CRC-8 of the 32-bit check word. The generator is x^8 + x^2 + x + 1 (0x07), the starting value is 0xFF, and the word is consumed most significant bit first, all 32 bits in one cycle.
- R3: Bit 0 of `rsp_crc` equals the XOR of check-word bits 0, 6, 7, 8, 12, 14, 16, 18, 19, 21, 23, 28, 30 and 31 with starting-value bits 4, 6 and 7.
- R4: Make (`req_op` = 0) returns `rsp_tag` = 0x80 OR the low seven bits of the CRC, with `rsp_status` = 0 (none).
- R5: Kill (`req_op` = 2) returns `tag_in` with bit 7 cleared and bits 6:0 unchanged, with `rsp_status` = 0.
- R6: Check (`req_op` = 1) reports `rsp_status` = 3 (invalid) whenever bit 7 of `tag_in` is clear, whatever its low bits hold.
- R7: Check with bit 7 of `tag_in` set reports `rsp_status` = 1 (match) when `tag_in[6:0]` equals CRC bits 6:0, and 2 (mismatch) otherwise. For a check, `rsp_tag` echoes `tag_in`.
- R8: `rsp_agg` is high exactly when the request's region is 2 or 4, for every operation.
- R9: A request accepted with `req_vld` high at a clock edge produces `rsp_vld` high, with its results, for the single following cycle. Op code 3 is reserved: it raises no `rsp_vld` and leaves every result output unchanged.
- R10: While `rst_n` is low, `rsp_vld`, `rsp_tag`, `rsp_crc`, `rsp_status` and `rsp_agg` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| req_op | input | 2 | 0 make, 1 check, 2 kill, 3 reserved |
| req_cid | input | 24 | Connection identifier |
| req_region | input | 4 | Region number |
| req_type | input | 4 | Context type code |
| tag_in | input | 8 | Stored tag for check or kill |
| rsp_vld | output | 1 | Response strobe, one cycle after the request |
| rsp_tag | output | 8 | Resulting tag byte |
| rsp_crc | output | 8 | Full CRC of the check word |
| rsp_status | output | 2 | 0 none, 1 match, 2 mismatch, 3 invalid |
| rsp_agg | output | 1 | Region is an aggregation region |

## Verification
A wrong bit in the packing or the CRC chain appears as a wrong `rsp_crc`, a wrong `rsp_tag` on make, and a wrong match or mismatch verdict on check. All of these show on the very response that follows the faulty request. Because the pipeline has a single register stage, any fault in the output register or the strobe logic is visible one cycle after the request. A stuck response strobe, or a result output that moves on a reserved op, shows on the next cycle. Random identifiers cover every check-word bit. Directed checks on the bit-0 equation and on all-zero and all-one inputs localise a faulty term.

// File: rtl/ctag_pkg.sv
package ctag_pkg;

    localparam int unsigned CID_W   = 24;
    localparam int unsigned REG_W   = 4;
    localparam int unsigned TYP_W   = 4;
    localparam int unsigned WORD_W  = CID_W + REG_W + TYP_W;
    localparam int unsigned CRC_W   = 8;
    localparam int unsigned TAG_W   = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam logic [CRC_W-1:0] CRC_SEED = 8'hFF;

    typedef enum logic [1:0] {
        CT_MAKE  = 2'd0,
        CT_CHECK = 2'd1,
        CT_KILL  = 2'd2,
        CT_RSVD  = 2'd3
    } ctag_op_e;

    typedef enum logic [1:0] {
        ST_NONE     = 2'd0,
        ST_MATCH    = 2'd1,
        ST_MISMATCH = 2'd2,
        ST_INVALID  = 2'd3
    } ctag_stat_e;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [CRC_W-1:0] crc;
        ctag_stat_e       stat;
        logic             agg;
    } ctag_rsp_t;

endpackage

// File: rtl/ctag_pack.sv
module ctag_pack #(
    parameter int unsigned ID_W = 24,
    parameter int unsigned RG_W = 4,
    parameter int unsigned TY_W = 4,
    localparam int unsigned OUT_W = ID_W + RG_W + TY_W
) (
    input  logic [ID_W-1:0]  cid,
    input  logic [RG_W-1:0]  region,
    input  logic [TY_W-1:0]  ctype,
    output logic [OUT_W-1:0] word
);
    // identifier on top, region in the middle, type in the low nibble
    always_comb begin
        word = {cid, region, ctype};
    end
endmodule

// File: rtl/ctag_crc_step.sv
module ctag_crc_step #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic [W-1:0] crc_in,
    input  logic         din,
    output logic [W-1:0] crc_out
);
    logic feedback;
    always_comb begin
        feedback = crc_in[W-1] ^ din;
        crc_out  = {crc_in[W-2:0], 1'b0} ^ (feedback ? POLY : '0);
    end
endmodule

// File: rtl/ctag_crc_par.sv
module ctag_crc_par #(
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 8,
    parameter logic [CW-1:0] POLY = 8'h07
) (
    input  logic [DW-1:0] data,
    input  logic [CW-1:0] seed,
    output logic [CW-1:0] crc
);
    // chain of DW combinational steps, flattened into one XOR network
    logic [CW-1:0] chain [DW+1];

    assign chain[0] = seed;

    for (genvar i = 0; i < DW; i++) begin : g_step
        ctag_crc_step #(.W(CW), .POLY(POLY)) u_step (
            .crc_in (chain[i]),
            .din    (data[DW-1-i]),
            .crc_out(chain[i+1])
        );
    end

    assign crc = chain[DW];
endmodule

// File: rtl/ctag_validator.sv
module ctag_validator
    import ctag_pkg::*;
#(
    parameter logic [REG_W-1:0] AGG_REGION_A = 4'd2,
    parameter logic [REG_W-1:0] AGG_REGION_B = 4'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic [1:0]       req_op,
    input  logic [CID_W-1:0] req_cid,
    input  logic [REG_W-1:0] req_region,
    input  logic [TYP_W-1:0] req_type,
    input  logic [TAG_W-1:0] tag_in,
    output logic             rsp_vld,
    output logic [TAG_W-1:0] rsp_tag,
    output logic [CRC_W-1:0] rsp_crc,
    output logic [1:0]       rsp_status,
    output logic             rsp_agg
);
    localparam int unsigned FLAG_BIT = TAG_W - 1;

    logic [WORD_W-1:0] chk_word;
    logic [CRC_W-1:0]  crc_now;
    ctag_op_e          op;
    ctag_rsp_t         rsp_d, rsp_q;

    ctag_pack #(.ID_W(CID_W), .RG_W(REG_W), .TY_W(TYP_W)) u_pack (
        .cid   (req_cid),
        .region(req_region),
        .ctype (req_type),
        .word  (chk_word)
    );

    ctag_crc_par #(.DW(WORD_W), .CW(CRC_W), .POLY(CRC_POLY)) u_crc (
        .data(chk_word),
        .seed(CRC_SEED),
        .crc (crc_now)
    );

    always_comb begin
        op        = ctag_op_e'(req_op);
        rsp_d     = rsp_q;
        rsp_d.vld = 1'b0;
        if (req_vld && op != CT_RSVD) begin
            rsp_d.vld  = 1'b1;
            rsp_d.crc  = crc_now;
            rsp_d.agg  = (req_region == AGG_REGION_A) || (req_region == AGG_REGION_B);
            rsp_d.stat = ST_NONE;
            unique case (op)
                CT_MAKE: rsp_d.tag = {1'b1, crc_now[FLAG_BIT-1:0]};
                CT_KILL: rsp_d.tag = {1'b0, tag_in[FLAG_BIT-1:0]};
                default: begin
                    rsp_d.tag = tag_in;
                    if (!tag_in[FLAG_BIT])
                        rsp_d.stat = ST_INVALID;
                    else if (tag_in[FLAG_BIT-1:0] == crc_now[FLAG_BIT-1:0])
                        rsp_d.stat = ST_MATCH;
                    else
                        rsp_d.stat = ST_MISMATCH;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_vld    = rsp_q.vld;
    assign rsp_tag    = rsp_q.tag;
    assign rsp_crc    = rsp_q.crc;
    assign rsp_status = rsp_q.stat;
    assign rsp_agg    = rsp_q.agg;

    // a response only ever follows a request
    p_vld_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $past(req_vld) && $past(req_op) != 2'd3);

    // a reserved op holds every result output
    p_rsvd_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd3) |=> !rsp_vld && $stable(rsp_tag) && $stable(rsp_crc)
                                        && $stable(rsp_status) && $stable(rsp_agg));

    // a made tag carries the flag and the CRC low bits
    p_make_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && $past(req_op) == 2'd0) |->
            rsp_tag[FLAG_BIT] && rsp_tag[FLAG_BIT-1:0] == rsp_crc[FLAG_BIT-1:0] && rsp_status == 2'd0);

    // a killed tag loses only its flag
    p_kill_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && $past(req_op) == 2'd2) |->
            !rsp_tag[FLAG_BIT] && rsp_tag[FLAG_BIT-1:0] == $past(tag_in[FLAG_BIT-1:0]));

    // an unflagged stored tag is always reported invalid
    p_unflagged_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && $past(req_op) == 2'd1 && !$past(tag_in[FLAG_BIT])) |-> rsp_status == 2'd3);

    // a flagged stored tag never yields invalid or none
    p_flagged_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && $past(req_op) == 2'd1 && $past(tag_in[FLAG_BIT])) |->
            (rsp_status == 2'd1) == (rsp_tag[FLAG_BIT-1:0] == rsp_crc[FLAG_BIT-1:0]) && rsp_status != 2'd3);

    // aggregation flag tracks the requested region
    p_agg_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> rsp_agg == ($past(req_region) == 4'd2 || $past(req_region) == 4'd4));
endmodule

// File: tb/ctag_validator_bench.sv
module ctag_validator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [23:0] req_cid = '0;
    logic [3:0]  req_region = '0;
    logic [3:0]  req_type = '0;
    logic [7:0]  tag_in = '0;
    logic        rsp_vld;
    logic [7:0]  rsp_tag;
    logic [7:0]  rsp_crc;
    logic [1:0]  rsp_status;
    logic        rsp_agg;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0] last_tag = '0, last_crc = '0;
    logic [1:0] last_stat = '0;
    logic       last_agg = 1'b0;

    always #4 clk = ~clk;

    ctag_validator u_ctag_validator (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
        .req_cid(req_cid), .req_region(req_region), .req_type(req_type),
        .tag_in(tag_in), .rsp_vld(rsp_vld), .rsp_tag(rsp_tag),
        .rsp_crc(rsp_crc), .rsp_status(rsp_status), .rsp_agg(rsp_agg)
    );

    // bit-serial reference, most significant bit first
    function automatic logic [7:0] ref_crc(logic [23:0] cid, logic [3:0] rg, logic [3:0] ty);
        logic [31:0] w;
        logic [7:0]  c;
        w = {cid, rg, ty};
        c = 8'hFF;
        for (int i = 31; i >= 0; i--) begin
            if (c[7] ^ w[i]) c = (c << 1) ^ 8'h07;
            else             c = c << 1;
        end
        return c;
    endfunction

    function automatic logic ref_bit0(logic [31:0] d);
        logic [7:0] s;
        s = 8'hFF;
        return d[31]^d[30]^d[28]^d[23]^d[21]^d[19]^d[18]^d[16]^d[14]^d[12]
              ^d[8]^d[7]^d[6]^d[0]^s[4]^s[6]^s[7];
    endfunction

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [1:0] op, logic [23:0] cid, logic [3:0] rg, logic [3:0] ty, logic [7:0] tg);
        logic [7:0] c;
        logic [7:0] et;
        logic [1:0] es;
        @(negedge clk);
        req_vld = 1'b1; req_op = op; req_cid = cid; req_region = rg; req_type = ty; tag_in = tg;
        @(negedge clk);
        req_vld = 1'b0;
        vectors++;
        c = ref_crc(cid, rg, ty);
        if (op == 2'd3) begin
            cmp("R9", "rsvd rsp_vld", {31'd0, rsp_vld}, 32'd0);
            cmp("R9", "rsvd tag hold", {24'd0, rsp_tag}, {24'd0, last_tag});
            cmp("R9", "rsvd crc hold", {24'd0, rsp_crc}, {24'd0, last_crc});
            cmp("R9", "rsvd status hold", {30'd0, rsp_status}, {30'd0, last_stat});
            cmp("R9", "rsvd agg hold", {31'd0, rsp_agg}, {31'd0, last_agg});
            return;
        end
        es = 2'd0;
        case (op)
            2'd0: et = {1'b1, c[6:0]};
            2'd2: et = {1'b0, tg[6:0]};
            default: begin
                et = tg;
                if (!tg[7])               es = 2'd3;
                else if (tg[6:0] == c[6:0]) es = 2'd1;
                else                        es = 2'd2;
            end
        endcase
        cmp("R9", "rsp_vld", {31'd0, rsp_vld}, 32'd1);
        cmp("R2", "rsp_crc", {24'd0, rsp_crc}, {24'd0, c});
        cmp("R3", "crc bit0", {31'd0, rsp_crc[0]}, {31'd0, ref_bit0({cid, rg, ty})});
        cmp(op == 2'd0 ? "R4" : (op == 2'd2 ? "R5" : "R7"), "rsp_tag", {24'd0, rsp_tag}, {24'd0, et});
        cmp(es == 2'd3 ? "R6" : "R7", "rsp_status", {30'd0, rsp_status}, {30'd0, es});
        cmp("R8", "rsp_agg", {31'd0, rsp_agg}, {31'd0, (rg == 4'd2 || rg == 4'd4)});
        last_tag = et; last_crc = c; last_stat = es; last_agg = (rg == 4'd2 || rg == 4'd4);
        @(negedge clk);
        cmp("R9", "strobe one cycle", {31'd0, rsp_vld}, 32'd0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        finished = 1;
        $finish;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            fails++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [7:0] c;
        process::self().srandom(32'd20240611);
        repeat (3) @(negedge clk);
        vectors++;
        // R10: reset state
        cmp("R10", "reset outputs", {15'd0, rsp_vld, rsp_tag, rsp_crc, rsp_status, rsp_agg}, 32'd0);
        rst_n = 1'b1;

        // R1 / R2 / R3 directed corners
        apply(2'd0, 24'h000000, 4'h0, 4'h0, 8'h00);
        apply(2'd0, 24'hFFFFFF, 4'hF, 4'hF, 8'h00);
        apply(2'd0, 24'h800000, 4'h0, 4'h0, 8'h00);   // R1: ID top bit
        apply(2'd0, 24'h000000, 4'h0, 4'h1, 8'h00);   // R1: type low bit
        apply(2'd0, 24'h000000, 4'h8, 4'h0, 8'h00);   // R1: region top bit
        apply(2'd0, 24'h123456, 4'h2, 4'h5, 8'h00);   // R8 region 2
        apply(2'd0, 24'h123456, 4'h4, 4'h5, 8'h00);   // R8 region 4
        apply(2'd0, 24'h123456, 4'h3, 4'h5, 8'h00);   // R8 other region
        // R7 match and mismatch, R6 invalid with matching low bits
        c = ref_crc(24'hABCDEF, 4'h4, 4'h9);
        apply(2'd1, 24'hABCDEF, 4'h4, 4'h9, {1'b1, c[6:0]});
        apply(2'd1, 24'hABCDEF, 4'h4, 4'h9, {1'b1, c[6:0] ^ 7'h01});
        apply(2'd1, 24'hABCDEF, 4'h4, 4'h9, {1'b0, c[6:0]});
        // R5 kill
        apply(2'd2, 24'hABCDEF, 4'h4, 4'h9, 8'hFF);
        apply(2'd2, 24'h000001, 4'h2, 4'h0, 8'h00);
        // R9 reserved op holds
        apply(2'd3, 24'h55AA55, 4'h2, 4'h3, 8'h81);

        for (int n = 0; n < 400; n++) begin
            logic [1:0]  op;
            logic [23:0] cid;
            logic [3:0]  rg, ty;
            logic [7:0]  tg;
            op  = 2'($urandom_range(0, 3));
            cid = 24'($urandom);
            rg  = 4'($urandom);
            ty  = 4'($urandom);
            tg  = 8'($urandom);
            c   = ref_crc(cid, rg, ty);
            if (op == 2'd1 && $urandom_range(0, 2) == 0) tg = {1'b1, c[6:0]};
            apply(op, cid, rg, ty, tg);
        end
        summary();
    end
endmodule